// File: doc/BRIEF.md
# Exception Entry State Update Unit

This block performs the single-cycle register update a processor makes when it takes a synchronous exception. It receives the current instruction address, the current machine state word, a cause code, a reason code, a store/load direction flag and a faulting effective address. On the clock edge where the take strobe is high, it loads its registered outputs:

- the two save/restore registers;
- the new machine state word;
- the data-fault address and data-fault status registers, for the causes that write them;
- a redirect address taken from a fixed vector table.

The redirect address comes with a one-cycle valid pulse. The unit also raises a double-fault error pulse when the exception arrives while the old state word marks the machine as not recoverable.

All registers are 64 bits. Bit positions are numbered with bit 0 as the most significant bit, so bit n lies at vector index 63-n.

Top module: `exc_entry_unit`

## Requirements
- R1: Cause codes are 0 machine check, 1 data storage, 2 instruction storage, 3 alignment, 4 program, 5 floating-point unavailable, 6 system call and 7 floating-point assist. Their vector offsets are 0x200, 0x300, 0x400, 0x600, 0x700, 0x800, 0xC00 and 0xE00. One cycle after an accepted strobe, redirect_valid_o pulses high for one cycle and redirect_addr_o holds base plus offset.
- R2: If bit 57 (prefix) of the new state word is 1, the base is 0xFFFF_FFFF_FFF0_0000 (bits 0 through 43 set). Otherwise the base is 0.
- R3: The new state word is the old one with these bits cleared: 45, 48, 49, 50, 52, 53, 54, 55, 58, 59 and 62. Bit 0 is forced to 1 and all other bits are copied unchanged.
- R4: save1 receives the old state word masked to bits 0–32, 37–41 and 48–63, ORed with the cause's reason bit.
- R5: save0 receives the instruction address, or that address plus 4 (modulo 2^64) for a system call.
- R6: A data storage fault loads dar_o with the effective address. It loads dsisr_o with a reason bit plus bit 38 when is_store_i is 1. Reason codes 0 to 5 (direct-store error, hash/translation miss, protection, external-access violation, segment miss, external access disabled) select bits 32, 33, 36, 43, 42 and 44. Any other reason code sets no reason bit.
- R7: An instruction storage fault ORs a reason bit into save1. Reason codes 0 to 3 (hash/translation miss, direct-store error, protection, segment miss) select bits 1, 3, 4 and 10. Causes other than data storage and alignment leave dar_o and dsisr_o unchanged.
- R8: A program exception ORs a reason bit into save1. Reason codes 0 to 4 (floating-point enabled, illegal, privileged, trap, unsupported optional) select bits 11, 12, 13, 14 and 12. Any other reason code, and any other cause, adds no reason bit.
- R9: An alignment exception loads dar_o with the effective address and clears dsisr_o.
- R10: If bit 62 (recoverable) of the old state word is 0 when a strobe is accepted, double_fault_o pulses high in the following cycle, and the entry update still takes place.
- R11: With take_i low, or with a cause code of 8 or above, no register changes and no redirect or double-fault pulse follows.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take-exception strobe |
| cause_i | input | 4 | Exception cause code |
| reason_i | input | 3 | Cause-specific reason code |
| is_store_i | input | 1 | Faulting access was a store |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state word |
| ea_i | input | 64 | Faulting effective address |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_addr_o | output | 64 | New fetch address |
| save0_o | output | 64 | First save/restore register |
| save1_o | output | 64 | Second save/restore register |
| msr_o | output | 64 | New machine state word |
| dar_o | output | 64 | Data-fault address register |
| dsisr_o | output | 64 | Data-fault status register |
| double_fault_o | output | 1 | Double-fault error pulse |

## Verification
The double-fault flag and the normal entry update can land in the same cycle. A strobe whose old state word has the recoverable bit clear must raise the error pulse and also produce a complete redirect and save. The bench provokes this both by directed cases and by random state words, where the recoverable bit is 0 about a quarter of the time. Each such cycle is judged by comparing every output against the bench model, not the error flag alone. Back-to-back strobes are also generated, so that one entry's pulses are checked against the inputs of the next.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int PREFIX_HI = 43
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic [3:0]  cause_i,
  input  logic [2:0]  reason_i,
  input  logic        is_store_i,
  input  logic [63:0] cia_i,
  input  logic [63:0] msr_i,
  input  logic [63:0] ea_i,
  output logic        redirect_valid_o,
  output logic [63:0] redirect_addr_o,
  output logic [63:0] save0_o,
  output logic [63:0] save1_o,
  output logic [63:0] msr_o,
  output logic [63:0] dar_o,
  output logic [63:0] dsisr_o,
  output logic        double_fault_o
);

  function automatic logic [63:0] pos(input int n);
    return 64'd1 << (63 - n);
  endfunction

  function automatic logic [63:0] span(input int a, input int b);
    logic [63:0] m;
    m = '0;
    for (int i = a; i <= b; i++) m |= pos(i);
    return m;
  endfunction

  localparam logic [63:0] ST_WIDE  = pos(0);
  localparam logic [63:0] ST_PFX   = pos(57);
  localparam logic [63:0] ST_RECOV = pos(62);
  localparam logic [63:0] ST_WIPE  = pos(45) | pos(48) | pos(49) | pos(50) | pos(52) |
                                     pos(53) | pos(54) | pos(55) | pos(58) | pos(59) | pos(62);
  localparam logic [63:0] KEEP1    = span(0, 32) | span(37, 41) | span(48, 63);
  localparam logic [63:0] HI_BASE  = span(0, PREFIX_HI);

  localparam logic [3:0] C_MCK = 4'd0, C_DST = 4'd1, C_IST = 4'd2, C_ALN = 4'd3,
                         C_PRG = 4'd4, C_FPU = 4'd5, C_SYS = 4'd6, C_FPA = 4'd7;

  logic        accept;
  logic [63:0] st_next, base, offs, save0_n, rsn1, rsn_ds;

  assign accept  = take_i && (cause_i < 4'd8);
  assign st_next = (msr_i & ~ST_WIPE) | ST_WIDE;
  assign base    = (st_next & ST_PFX) != '0 ? HI_BASE : '0;
  assign save0_n = (cause_i == C_SYS) ? cia_i + 64'd4 : cia_i;

  always_comb begin
    unique case (cause_i)
      C_MCK:   offs = 64'h200;
      C_DST:   offs = 64'h300;
      C_IST:   offs = 64'h400;
      C_ALN:   offs = 64'h600;
      C_PRG:   offs = 64'h700;
      C_FPU:   offs = 64'h800;
      C_SYS:   offs = 64'hC00;
      C_FPA:   offs = 64'hE00;
      default: offs = '0;
    endcase
  end

  always_comb begin
    rsn1 = '0;
    if (cause_i == C_IST) begin
      case (reason_i)
        3'd0:    rsn1 = pos(1);
        3'd1:    rsn1 = pos(3);
        3'd2:    rsn1 = pos(4);
        3'd3:    rsn1 = pos(10);
        default: rsn1 = '0;
      endcase
    end else if (cause_i == C_PRG) begin
      case (reason_i)
        3'd0:       rsn1 = pos(11);
        3'd1, 3'd4: rsn1 = pos(12);
        3'd2:       rsn1 = pos(13);
        3'd3:       rsn1 = pos(14);
        default:    rsn1 = '0;
      endcase
    end
  end

  always_comb begin
    case (reason_i)
      3'd0:    rsn_ds = pos(32);
      3'd1:    rsn_ds = pos(33);
      3'd2:    rsn_ds = pos(36);
      3'd3:    rsn_ds = pos(43);
      3'd4:    rsn_ds = pos(42);
      3'd5:    rsn_ds = pos(44);
      default: rsn_ds = '0;
    endcase
    if (is_store_i) rsn_ds |= pos(38);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid_o <= 1'b0;
      redirect_addr_o  <= '0;
      save0_o          <= '0;
      save1_o          <= '0;
      msr_o            <= '0;
      dar_o            <= '0;
      dsisr_o          <= '0;
      double_fault_o   <= 1'b0;
    end else begin
      redirect_valid_o <= accept;
      double_fault_o   <= accept && ((msr_i & ST_RECOV) == '0);
      if (accept) begin
        redirect_addr_o <= base | offs;
        save0_o         <= save0_n;
        save1_o         <= (msr_i & KEEP1) | rsn1;
        msr_o           <= st_next;
        if (cause_i == C_DST) begin
          dar_o   <= ea_i;
          dsisr_o <= rsn_ds;
        end else if (cause_i == C_ALN) begin
          dar_o   <= ea_i;
          dsisr_o <= '0;
        end
      end
    end
  end

endmodule

module exc_entry_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_i,
  input logic [3:0]  cause_i,
  input logic [63:0] cia_i,
  input logic [63:0] msr_i,
  input logic        redirect_valid_o,
  input logic [63:0] redirect_addr_o,
  input logic [63:0] save0_o,
  input logic [63:0] msr_o,
  input logic [63:0] dar_o,
  input logic [63:0] dsisr_o,
  input logic        double_fault_o
);
  logic ok;
  assign ok = take_i && (cause_i < 4'd8);

  a_r1_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> redirect_valid_o);
  a_r1_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> redirect_addr_o[7:0] == 8'h00);
  a_r3_state_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> (msr_o[63] && !msr_o[1] && !msr_o[15] && !msr_o[14]));
  a_r5_save_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && cause_i != 4'd6) |=> save0_o == $past(cia_i));
  a_r7_dar_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i != 4'd1 && cause_i != 4'd3) |=> ($stable(dar_o) && $stable(dsisr_o)));
  a_r10_double_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !msr_i[1]) |=> (double_fault_o && redirect_valid_o));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |=> (!redirect_valid_o && !double_fault_o && $stable(msr_o) && $stable(save0_o)));
endmodule

bind exc_entry_unit exc_entry_unit_chk u_chk (.*);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [3:0]  cause_i = '0;
  logic [2:0]  reason_i = '0;
  logic        is_store_i = 1'b0;
  logic [63:0] cia_i = '0, msr_i = '0, ea_i = '0;
  logic        redirect_valid_o, double_fault_o;
  logic [63:0] redirect_addr_o, save0_o, save1_o, msr_o, dar_o, dsisr_o;

  int checks = 0, fails = 0;
  logic        e_rv, e_df;
  logic [63:0] e_ra, e_s0, e_s1, e_st, e_dar, e_dsisr;

  always #2.5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (.*);

  function automatic logic [63:0] b(input int n);
    logic [63:0] v;
    v = '0;
    v[63 - n] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] m_state(input logic [63:0] old);
    logic [63:0] r;
    int wipe[11] = '{45, 48, 49, 50, 52, 53, 54, 55, 58, 59, 62};
    r = old;
    foreach (wipe[k]) r[63 - wipe[k]] = 1'b0;
    r[63] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] m_vec(input logic [3:0] c, input logic [63:0] st);
    logic [63:0] o;
    o = 64'h200;
    case (c)
      4'd1: o = 64'h300;
      4'd2: o = 64'h400;
      4'd3: o = 64'h600;
      4'd4: o = 64'h700;
      4'd5: o = 64'h800;
      4'd6: o = 64'hC00;
      4'd7: o = 64'hE00;
      default: o = 64'h200;
    endcase
    return (st[63 - 57] ? 64'hFFFF_FFFF_FFF0_0000 : 64'd0) + o;
  endfunction

  function automatic logic [63:0] m_save1(input logic [3:0] c, input logic [2:0] r, input logic [63:0] old);
    logic [63:0] v;
    v = '0;
    for (int n = 0; n < 64; n++)
      if (n <= 32 || (n >= 37 && n <= 41) || n >= 48) v[63 - n] = old[63 - n];
    if (c == 4'd2) begin
      if (r == 0) v |= b(1);
      if (r == 1) v |= b(3);
      if (r == 2) v |= b(4);
      if (r == 3) v |= b(10);
    end
    if (c == 4'd4) begin
      if (r == 0) v |= b(11);
      if (r == 1 || r == 4) v |= b(12);
      if (r == 2) v |= b(13);
      if (r == 3) v |= b(14);
    end
    return v;
  endfunction

  function automatic logic [63:0] m_dsisr(input logic [2:0] r, input logic st);
    logic [63:0] v;
    v = st ? b(38) : 64'd0;
    case (r)
      3'd0: v |= b(32);
      3'd1: v |= b(33);
      3'd2: v |= b(36);
      3'd3: v |= b(43);
      3'd4: v |= b(42);
      3'd5: v |= b(44);
      default: ;
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input logic [3:0] c);
    chk("R1", "redirect_valid", {63'd0, redirect_valid_o}, {63'd0, e_rv});
    chk((c == 4'd6) ? "R5" : "R1", "redirect_addr", redirect_addr_o, e_ra);
    chk("R5", "save0", save0_o, e_s0);
    chk((c == 4'd2) ? "R7" : (c == 4'd4) ? "R8" : "R4", "save1", save1_o, e_s1);
    chk("R3", "state", msr_o, e_st);
    chk((c == 4'd3) ? "R9" : "R6", "dar", dar_o, e_dar);
    chk((c == 4'd3) ? "R9" : "R6", "dsisr", dsisr_o, e_dsisr);
    chk("R10", "double_fault", {63'd0, double_fault_o}, {63'd0, e_df});
  endtask

  task automatic step(input logic t, input logic [3:0] c, input logic [2:0] r, input logic s,
                      input logic [63:0] pc, input logic [63:0] st, input logic [63:0] ea);
    logic ok;
    take_i = t; cause_i = c; reason_i = r; is_store_i = s; cia_i = pc; msr_i = st; ea_i = ea;
    ok = t && (c < 4'd8);
    e_rv = ok;
    e_df = ok && !st[63 - 62];
    if (ok) begin
      e_st = m_state(st);
      e_ra = m_vec(c, e_st);
      e_s0 = (c == 4'd6) ? pc + 64'd4 : pc;
      e_s1 = m_save1(c, r, st);
      if (c == 4'd1) begin e_dar = ea; e_dsisr = m_dsisr(r, s); end
      if (c == 4'd3) begin e_dar = ea; e_dsisr = '0; end
    end
    @(negedge clk);
    take_i = 1'b0;
    compare_all(c);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] st;
    void'($urandom(32'd4242));
    e_rv = 0; e_df = 0; e_ra = '0; e_s0 = '0; e_s1 = '0; e_st = '0; e_dar = '0; e_dsisr = '0;
    repeat (3) @(negedge clk);
    compare_all(4'd0);               // R12 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(4'd0);               // R12 held after reset release

    // R1/R3 every cause, recoverable, prefix clear
    for (int c = 0; c < 8; c++)
      step(1, 4'(c), 3'd0, 0, 64'h1000 + 64'(c) * 4, ~b(57), 64'hABCD_0000 + 64'(c));
    // R2 prefix set
    step(1, 4'd4, 3'd3, 0, 64'h2000, b(57) | b(62), 64'd0);
    // R5 system call wrap
    step(1, 4'd6, 3'd0, 0, 64'hFFFF_FFFF_FFFF_FFFC, b(62), 64'd0);
    // R6 each data-storage reason, both directions, and an unlisted reason
    for (int r = 0; r < 8; r++)
      for (int s = 0; s < 2; s++)
        step(1, 4'd1, 3'(r), 1'(s), 64'h3000, b(62) | b(48), 64'h5555_0000 + 64'(r));
    // R7 / R8 reasons
    for (int r = 0; r < 8; r++) step(1, 4'd2, 3'(r), 0, 64'h4000, b(62), 64'd7);
    for (int r = 0; r < 8; r++) step(1, 4'd4, 3'(r), 0, 64'h4400, b(62), 64'd8);
    // R9 alignment after a populated status
    step(1, 4'd1, 3'd2, 1, 64'h5000, b(62), 64'h77);
    step(1, 4'd3, 3'd0, 1, 64'h5004, b(62), 64'h99);
    // R10 double fault with a full entry in the same cycle
    step(1, 4'd0, 3'd0, 0, 64'h6000, ~b(62), 64'd0);
    step(1, 4'd6, 3'd0, 0, 64'h6004, 64'd0, 64'd0);
    // R11 no strobe, and invalid cause codes
    step(0, 4'd1, 3'd0, 1, 64'h7000, 64'd0, 64'hDEAD);
    step(1, 4'd8, 3'd1, 1, 64'h7004, 64'd0, 64'hBEEF);
    step(1, 4'd15, 3'd1, 1, 64'h7008, 64'd0, 64'hBEEF);

    // random mix, back-to-back strobes included
    for (int i = 0; i < 400; i++) begin
      st = r64();
      st[63 - 62] = ($urandom_range(3) != 0);
      step($urandom_range(4) != 0, 4'($urandom_range(9)), 3'($urandom_range(7)),
           1'($urandom_range(1)), r64(), st, r64());
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule